// File: doc/BRIEF.md
# Interval Timer with Sticky Interrupt Flag

This block holds a free-running binary up-counter that advances once per clock while its count-enable input is high. One of four counter bits can be chosen as the interval tap. Each time the chosen tap bit falls from 1 to 0, a sticky interrupt flag is raised. The interrupt output is driven when the flag and an enable bit are both set. Software controls the timer through a single write port and reads it back through a combinational read word. One bit of that word restarts the counter from zero when a 0 is written to it. Because of that restart, intervals are always measured from the most recent counter restart.

The flag is held by a two-state machine. In state `FLAG_IDLE` no event is pending. In state `FLAG_PENDING` an event is waiting for software. The transition `raise` goes from `FLAG_IDLE` to `FLAG_PENDING` when a qualified tap falling edge arrives. The transition `ack` goes from `FLAG_PENDING` to `FLAG_IDLE` when software writes 0 to the flag bit and no new edge arrives in the same cycle. If neither condition applies, the machine stays in its current state. The counter and the tap-edge reference are plain registers in a separate module.

Top module: `interval_timer`

## Requirements
- R1: A write with bit 0 = 0 loads the counter with zero and loads the tap-edge reference with zero. The next interval event therefore falls a full period after that write. A write with bit 0 = 1 leaves the counter untouched.
- R2: Bit 0 of `rd_data` always reads 1.
- R3: While `cnt_en` is high and no restart is written, the counter increases by one per clock. It wraps from all ones (0x7FFFFF by default) to zero and keeps counting.
- R4: Select value s picks tap bit TAP_LO + TAP_STEP*s (by default 00→16, 01→18, 10→20, 11→22). Let P = 2^(tap+1). Counting from a restart, the flag goes to 1 on the clock after the counter reaches P, and another event follows every P counts. The enable bit does not affect this.
- R5: The flag stays at 1 until a write with bit 1 = 0 clears it. A write with bit 1 = 1 leaves the flag unchanged. If a flag-clearing write and a tap falling edge arrive in the same cycle, the flag stays at 1.
- R6: If a counter restart is written in the same cycle as a tap falling edge, the flag is not set by that edge.
- R7: While `cnt_en` is low, the counter holds its value and no interval event is produced. Counting resumes from the held value when `cnt_en` returns high.
- R8: `irq` is high exactly when the flag is 1 and the enable bit is 1. If the enable bit is written to 1 while the flag is already 1, `irq` rises on the clock that takes the write.
- R9: Every write loads the enable bit from bit 2 and the select field from bits 4:3. The read word is {select, enable, flag, 1}. After reset the counter, flag, enable and select are all zero, so `rd_data` reads 5'b00001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | High while the counting clock is running |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | SEL_W+3 | Written word: bit 0 restart (active 0), bit 1 flag (active-0 clear), bit 2 enable, bits 4:3 select |
| rd_data | output | SEL_W+3 | Read word {select, enable, flag, 1} |
| irq | output | 1 | Interrupt request: flag AND enable |

## Verification
A write sampled at clock edge E0 zeroes the counter after E0, and the counter then holds value k after the k-th enabled edge. The tap falls when the count reaches P, and the flag is registered one edge later, so it first reads 1 after edge P+1. Enable, select and flag-clear writes appear in `rd_data` and `irq` right after the edge that takes them. The bench drives stimulus on falling clock edges and samples on falling clock edges. It keeps its own count of enabled edges since the last restart and checks the flag on every cycle of each sweep. Restart and flag-clear writes are placed on the exact edge of a predicted falling edge to test the two same-cycle priorities.

// File: rtl/itim_pkg.sv
package itim_pkg;
    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_e;

    localparam int BIT_RESTART = 0;
    localparam int BIT_FLAG    = 1;
    localparam int BIT_ENABLE  = 2;
    localparam int BIT_SEL_LO  = 3;
endpackage

// File: rtl/itim_counter.sv
module itim_counter #(
    parameter int CNT_W    = 23,
    parameter int SEL_W    = 2,
    parameter int TAP_LO   = 16,
    parameter int TAP_STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             cnt_clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tap_fall
);
    localparam int NUM_TAPS = 1 << SEL_W;
    localparam int TAP_HI   = TAP_LO + TAP_STEP * (NUM_TAPS - 1);

    logic [CNT_W-1:0]    cnt_q;
    logic [NUM_TAPS-1:0] taps;
    logic                tap_now;
    logic                tap_q;

    initial begin
        if (TAP_HI >= CNT_W) $error("highest tap outside counter");
    end

    for (genvar gi = 0; gi < NUM_TAPS; gi++) begin : g_tap
        assign taps[gi] = cnt_q[TAP_LO + TAP_STEP * gi];
    end

    assign tap_now = taps[sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tap_q <= 1'b0;
        end else if (cnt_clr) begin
            cnt_q <= '0;
            tap_q <= 1'b0;
        end else if (cnt_en) begin
            cnt_q <= cnt_q + 1'b1;
            tap_q <= tap_now;
        end
    end

    assign tap_fall = cnt_en & ~cnt_clr & tap_q & ~tap_now;

    assert_restart_zeroes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (cnt_q == '0));
    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !cnt_clr) |=> (cnt_q == $past(cnt_q) + 1'b1));
    assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !cnt_clr) |=> $stable(cnt_q));
endmodule

// File: rtl/itim_flag_fsm.sv
module itim_flag_fsm
    import itim_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic sw_clr,
    input  logic cnt_clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    flag_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE:    if (set_ev) state_d = FLAG_PENDING;
            FLAG_PENDING: if (sw_clr && !set_ev) state_d = FLAG_IDLE;
            default:      state_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        flag = (state_q == FLAG_PENDING);
        irq  = flag & irq_en;
    end

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !sw_clr) |=> flag);
    assert_set_beats_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev |=> flag);
    assert_restart_blocks_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clr && !flag) |=> !flag);
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import itim_pkg::*;
#(
    parameter int CNT_W    = 23,
    parameter int SEL_W    = 2,
    parameter int TAP_LO   = 16,
    parameter int TAP_STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             wr_en,
    input  logic [SEL_W+2:0] wr_data,
    output logic [SEL_W+2:0] rd_data,
    output logic             irq
);
    localparam int SEL_HI = BIT_SEL_LO + SEL_W - 1;

    logic             cnt_clr;
    logic             sw_clr;
    logic             tap_fall;
    logic             flag;
    logic             en_q;
    logic [SEL_W-1:0] sel_q;

    assign cnt_clr = wr_en & ~wr_data[BIT_RESTART];
    assign sw_clr  = wr_en & ~wr_data[BIT_FLAG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            sel_q <= '0;
        end else if (wr_en) begin
            en_q  <= wr_data[BIT_ENABLE];
            sel_q <= wr_data[SEL_HI:BIT_SEL_LO];
        end
    end

    itim_counter #(
        .CNT_W   (CNT_W),
        .SEL_W   (SEL_W),
        .TAP_LO  (TAP_LO),
        .TAP_STEP(TAP_STEP)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (cnt_en),
        .cnt_clr (cnt_clr),
        .sel     (sel_q),
        .tap_fall(tap_fall)
    );

    itim_flag_fsm u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (tap_fall),
        .sw_clr (sw_clr),
        .cnt_clr(cnt_clr),
        .irq_en (en_q),
        .flag   (flag),
        .irq    (irq)
    );

    assign rd_data = {sel_q, en_q, flag, 1'b1};

    assert_enable_raises_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[BIT_ENABLE] && flag && !sw_clr) |=> irq);
    assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[BIT_ENABLE]) |=> !irq);
endmodule

// File: tb/test_interval_timer.sv
`timescale 1ns/1ps
module test_interval_timer;
    localparam int  CNT_W = 8;
    localparam int  SEL_W = 2;
    localparam time TCLK  = 20ns;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cnt_en;
    logic       wr_en;
    logic [4:0] wr_data;
    logic [4:0] rd_data;
    logic       irq;

    int total = 0;
    int fails = 0;
    int k     = 0;

    always #(TCLK/2) clk = ~clk;

    interval_timer #(.CNT_W(CNT_W), .SEL_W(SEL_W), .TAP_LO(1), .TAP_STEP(2)) i_interval_timer (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (k=%0d)", req, act, exp, k);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        if (cnt_en) k++;
    endtask

    task automatic wr(bit clr, bit flg, bit en, int sel);
        wr_en   = 1'b1;
        wr_data = {sel[1:0], en, flg, clr};
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        if (!clr) k = 0;
        else if (cnt_en) k++;
    endtask

    function automatic int period(int sel);
        return 1 << (2 + 2 * sel);
    endfunction

    initial begin
        #(TCLK * 200000);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cnt_en = 1'b1; wr_en = 1'b0; wr_data = '0;
        repeat (3) @(negedge clk);
        chk("R9 reset read word", rd_data, 5'b00001);
        chk("R9 reset irq", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);
        k = 0;

        // R4 and R3: sweep every select value; sel 3 uses the top bit, so its event is the wrap
        for (int s = 0; s < 4; s++) begin
            wr(0, 0, 0, s);
            chk("R2 restart bit reads one", rd_data[0], 1);
            chk("R9 select readback", rd_data[4:3], s);
            chk("R5 write zero clears flag", rd_data[1], 0);
            for (int n = 1; n <= period(s) + 1; n++) begin
                step();
                chk(s == 3 ? "R3 wrap event" : "R4 first event", rd_data[1], (k == period(s) + 1) ? 1 : 0);
            end
        end

        // R8 and R5: flag is 1 here
        wr(1, 1, 1, 3);
        chk("R5 write one keeps flag", rd_data[1], 1);
        chk("R8 irq rises with enable", irq, 1);
        wr(1, 1, 0, 3);
        chk("R8 irq drops with enable", irq, 0);
        wr(1, 0, 1, 3);
        chk("R8 irq low once flag cleared", irq, 0);
        chk("R9 enable readback", rd_data[2], 1);

        // R4 periodic events, R1 writes with bit0=1 keep timing
        wr(0, 0, 0, 0);
        while (k < 4) begin step(); chk("R4 before first event", rd_data[1], 0); end
        step();
        chk("R4 first event sel0", rd_data[1], 1);
        wr(1, 0, 0, 0);
        chk("R5 software clear", rd_data[1], 0);
        while (k < 8) begin step(); chk("R1 no restart on bit0=1", rd_data[1], 0); end
        step();
        chk("R4 second event", rd_data[1], 1);
        while (k < 12) step();
        wr(1, 0, 0, 0);
        chk("R5 set beats clear", rd_data[1], 1);
        wr(1, 0, 0, 0);
        chk("R5 clear after collision", rd_data[1], 0);

        // R6: restart landing on the tap edge
        while (k < 16) step();
        wr(0, 1, 0, 0);
        chk("R6 restart suppresses edge", rd_data[1], 0);
        while (k < 4) begin step(); chk("R1 interval restarts", rd_data[1], 0); end
        step();
        chk("R1 event after restart", rd_data[1], 1);

        // R7: freeze mid-interval
        wr(0, 0, 0, 0);
        step(); step();
        cnt_en = 1'b0;
        for (int n = 0; n < 10; n++) begin
            step();
            chk("R7 frozen no event", rd_data[1], 0);
        end
        cnt_en = 1'b1;
        while (k < 4) begin step(); chk("R7 resumed count", rd_data[1], 0); end
        step();
        chk("R7 event after resume", rd_data[1], 1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule